// File: doc/BRIEF.md
# UART Interrupt Priority and Identification

This block gathers the interrupt sources of a register-mapped serial port, masks each with its own enable bit, and reports the most urgent pending one. The sources are line status errors, received data available, receive FIFO timeout, transmit holding register empty, and modem status change. The host reads the result as an 8-bit identification value, and the block drives a single interrupt request line.

The serial engines sit outside this block. Each engine raises a one-cycle event or a level for its condition. The host side gives one-cycle strobes for each register access that clears a source.

Line status, transmit-empty and modem status events are held in sticky flags until the access that clears them. Received data available follows its level input. The timeout source is measured here by counting character-time ticks.

Top module: `uart_irq_id`

## Requirements
- R1: A write to the enable register stores bits 3..0 (bit 0 = receive data and timeout, bit 1 = transmit empty, bit 2 = line status, bit 3 = modem status); the readback value always has bits 7..4 at zero and is zero after reset.
- R2: Identification bit 0 is 1 when no enabled source is pending and 0 otherwise; `irq` is always the inverse of that bit, and after reset the identification value is 0x01.
- R3: With several enabled sources pending, bits 2..1 report the most urgent: 11 line status, 10 receive data (or timeout), 01 transmit empty, 00 modem status, in that order of precedence.
- R4: A line status error event sets a pending flag that stays set until a read of the line status register.
- R5: The receive data source follows the `rx_ready` level, so it drops once the receive buffer read empties the buffer.
- R6: A modem status change event sets a pending flag that stays set until a read of the modem status register.
- R7: A transmit-empty event sets a flag that is cleared by a write to the transmit holding register, or by an identification read that reports it (value bits 3..0 = 0010); an identification read that reports another source leaves it set.
- R8: A disabled source is not reported and does not raise `irq`, but its flag is kept and appears once its enable bit is set.
- R9: Identification bits 7..6 are 11 in FIFO mode and 00 otherwise; bit 3 and bits 5..4 are 0 outside FIFO mode.
- R10: In FIFO mode, with the receive FIFO non-empty and no character received and no buffer read for `TO_CHARS` character-time ticks, a timeout is reported as bits 3..1 = 110 (below line status, above transmit empty); a buffer read or a new character clears it.
- R11: A set event in the same cycle as the access that clears its flag leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ien_we | input | 1 | Enable register write strobe |
| ien_wdata | input | 8 | Enable register write data |
| ien_rdata | output | 8 | Enable register readback |
| fifo_mode | input | 1 | FIFOs enabled |
| ls_evt | input | 1 | Line status error event |
| rx_ready | input | 1 | Receive data available level |
| thr_evt | input | 1 | Holding register emptied event |
| ms_evt | input | 1 | Modem status change event |
| rx_fifo_nonempty | input | 1 | Receive FIFO holds data |
| rx_char_evt | input | 1 | A character was received |
| char_tick | input | 1 | One pulse per character time |
| iir_rd | input | 1 | Identification register read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| rbr_rd | input | 1 | Receive buffer read strobe |
| lsr_rd | input | 1 | Line status read strobe |
| msr_rd | input | 1 | Modem status read strobe |
| iir | output | 8 | Identification value |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume that every event and access input is a single-cycle pulse. They also assume that the enable register is not written in the cycle whose effect they judge, which is why the enable-dependent properties exclude `ien_we`. The stimulus drives strobes for exactly one cycle and writes enables in cycles of their own. Each check is separated from the next by a full clock, so every flag has settled before the next event.

// File: rtl/uart_irq_id.sv
module uart_irq_id #(
  parameter int TO_CHARS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ien_we,
  input  logic [7:0] ien_wdata,
  output logic [7:0] ien_rdata,
  input  logic       fifo_mode,
  input  logic       ls_evt,
  input  logic       rx_ready,
  input  logic       thr_evt,
  input  logic       ms_evt,
  input  logic       rx_fifo_nonempty,
  input  logic       rx_char_evt,
  input  logic       char_tick,
  input  logic       iir_rd,
  input  logic       thr_wr,
  input  logic       rbr_rd,
  input  logic       lsr_rd,
  input  logic       msr_rd,
  output logic [7:0] iir,
  output logic       irq
);
  localparam int CW = $clog2(TO_CHARS + 1);

  logic [3:0]    ien;
  logic          ls_q, thr_q, ms_q;
  logic [CW-1:0] to_cnt;
  logic [1:0]    id;
  logic          to_bit;

  wire to_hit = (to_cnt == CW'(TO_CHARS));
  wire ls_p   = ls_q & ien[2];
  wire rd_p   = rx_ready & ien[0];
  wire to_p   = fifo_mode & to_hit & ien[0];
  wire th_p   = thr_q & ien[1];
  wire ms_p   = ms_q & ien[3];
  wire any_p  = ls_p | rd_p | to_p | th_p | ms_p;

  always_comb begin
    id     = 2'b00;
    to_bit = 1'b0;
    if (ls_p)      id = 2'b11;
    else if (rd_p) id = 2'b10;
    else if (to_p) begin
      id     = 2'b10;
      to_bit = 1'b1;
    end
    else if (th_p) id = 2'b01;
  end

  assign iir       = {fifo_mode, fifo_mode, 2'b00, to_bit, id, ~any_p};
  assign irq       = any_p;
  assign ien_rdata = {4'b0000, ien};

  wire thr_clr = thr_wr | (iir_rd & (iir[3:0] == 4'b0010));
  wire to_rst  = ~fifo_mode | ~rx_fifo_nonempty | rx_char_evt | rbr_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien    <= '0;
      ls_q   <= 1'b0;
      thr_q  <= 1'b0;
      ms_q   <= 1'b0;
      to_cnt <= '0;
    end else begin
      if (ien_we) ien <= ien_wdata[3:0];
      ls_q  <= ls_evt  | (ls_q  & ~lsr_rd);
      thr_q <= thr_evt | (thr_q & ~thr_clr);
      ms_q  <= ms_evt  | (ms_q  & ~msr_rd);
      if (to_rst)                    to_cnt <= '0;
      else if (char_tick && !to_hit) to_cnt <= to_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/uart_irq_id_chk.sv
module uart_irq_id_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ien_we,
  input logic [7:0] ien_rdata,
  input logic       fifo_mode,
  input logic       ls_evt,
  input logic       rx_ready,
  input logic       thr_evt,
  input logic       thr_wr,
  input logic       lsr_rd,
  input logic [7:0] iir,
  input logic       irq
);
  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ien_rdata[7:4] == 4'b0000);

  p_irq_inv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq == !iir[0]);

  p_rx_over_lower_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && ien_rdata[0] && iir[2:1] != 2'b11) |-> iir[3:0] == 4'b0100);

  p_ls_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_evt && ien_rdata[2] && !ien_we) |=> iir[3:0] == 4'b0110);

  p_ls_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !ls_evt) |=> iir[2:1] != 2'b11);

  p_thr_wr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && !thr_evt) |=> iir[3:0] != 4'b0010);

  p_nofifo_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode |-> (iir[7:3] == 5'b00000));
endmodule

bind uart_irq_id uart_irq_id_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ien_we(ien_we), .ien_rdata(ien_rdata),
  .fifo_mode(fifo_mode), .ls_evt(ls_evt), .rx_ready(rx_ready),
  .thr_evt(thr_evt), .thr_wr(thr_wr), .lsr_rd(lsr_rd),
  .iir(iir), .irq(irq)
);

// File: tb/tb_uart_irq_id.sv
`timescale 1ns/1ps
module tb_uart_irq_id;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ien_we = 0, fifo_mode = 0, ls_evt = 0, rx_ready = 0, thr_evt = 0, ms_evt = 0;
  logic rx_fifo_nonempty = 0, rx_char_evt = 0, char_tick = 0;
  logic iir_rd = 0, thr_wr = 0, rbr_rd = 0, lsr_rd = 0, msr_rd = 0;
  logic [7:0] ien_wdata = 0;
  logic [7:0] ien_rdata, iir;
  logic irq;

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  uart_irq_id dut (
    .clk(clk), .rst_n(rst_n), .ien_we(ien_we), .ien_wdata(ien_wdata), .ien_rdata(ien_rdata),
    .fifo_mode(fifo_mode), .ls_evt(ls_evt), .rx_ready(rx_ready), .thr_evt(thr_evt),
    .ms_evt(ms_evt), .rx_fifo_nonempty(rx_fifo_nonempty), .rx_char_evt(rx_char_evt),
    .char_tick(char_tick), .iir_rd(iir_rd), .thr_wr(thr_wr), .rbr_rd(rbr_rd),
    .lsr_rd(lsr_rd), .msr_rd(msr_rd), .iir(iir), .irq(irq)
  );

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (iir !== e || irq !== ~e[0]) begin
        bad++;
        $display("FAIL %s: iir=%02h irq=%b expected iir=%02h irq=%b", t, iir, irq, e, ~e[0]);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
    ien_we = 0; ls_evt = 0; thr_evt = 0; ms_evt = 0; rx_char_evt = 0; char_tick = 0;
    iir_rd = 0; thr_wr = 0; rbr_rd = 0; lsr_rd = 0; msr_rd = 0;
  endtask

  task automatic expect_iir(input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    #0.5;
  endtask

  task automatic set_ien(input logic [7:0] v, input logic [7:0] rb, input string t);
    ien_we = 1; ien_wdata = v;
    tick();
    total++;
    if (ien_rdata !== rb) begin
      bad++;
      $display("FAIL %s: ien_rdata=%02h expected %02h", t, ien_rdata, rb);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    total++;
    if (ien_rdata !== 8'h00) begin
      bad++;
      $display("FAIL R1 reset: ien_rdata=%02h expected 00", ien_rdata);
    end
    expect_iir(8'h01, "R2 reset idle");

    set_ien(8'hFF, 8'h0F, "R1 upper bits read zero");
    ms_evt = 1; tick();           expect_iir(8'h00, "R6 modem status set");
    thr_evt = 1; tick();          expect_iir(8'h02, "R3 transmit over modem");
    rx_ready = 1; tick();         expect_iir(8'h04, "R3 receive over transmit");
    ls_evt = 1; tick();           expect_iir(8'h06, "R4 line status highest");
    tick();                       expect_iir(8'h06, "R4 line status held");
    lsr_rd = 1; tick();           expect_iir(8'h04, "R4 line status cleared");
    iir_rd = 1; tick();           expect_iir(8'h04, "R7 id read of other source");
    rx_ready = 0; tick();         expect_iir(8'h02, "R5 receive level dropped, R7 kept");
    iir_rd = 1; tick();           expect_iir(8'h00, "R7 id read clears transmit");
    msr_rd = 1; tick();           expect_iir(8'h01, "R6 modem status cleared");

    set_ien(8'h00, 8'h00, "R1 disable all");
    thr_evt = 1; tick();          expect_iir(8'h01, "R8 masked transmit");
    ls_evt = 1; tick();           expect_iir(8'h01, "R8 masked line status");
    set_ien(8'h02, 8'h02, "R1 enable transmit");
    expect_iir(8'h02, "R8 kept flag appears");
    thr_wr = 1; tick();           expect_iir(8'h01, "R7 holding write clears");
    set_ien(8'h04, 8'h04, "R1 enable line status");
    expect_iir(8'h07 & 8'h06, "R8 kept line status appears");
    lsr_rd = 1; tick();           expect_iir(8'h01, "R4 cleared after unmask");

    set_ien(8'h0A, 8'h0A, "R1 enable modem and transmit");
    ms_evt = 1; tick();           expect_iir(8'h00, "R11 modem set");
    ms_evt = 1; msr_rd = 1; tick(); expect_iir(8'h00, "R11 set wins over clear");
    msr_rd = 1; tick();           expect_iir(8'h01, "R6 cleared");
    thr_evt = 1; thr_wr = 1; tick(); expect_iir(8'h02, "R11 transmit set wins");
    thr_wr = 1; tick();           expect_iir(8'h01, "R7 cleared by write");

    set_ien(8'h01, 8'h01, "R1 enable receive");
    fifo_mode = 1; tick();        expect_iir(8'hC1, "R9 fifo mode bits");
    rx_fifo_nonempty = 1;
    for (int i = 0; i < 3; i++) begin char_tick = 1; tick(); end
    expect_iir(8'hC1, "R10 three ticks no timeout");
    char_tick = 1; tick();        expect_iir(8'hCC, "R10 timeout reported");
    rx_ready = 1; tick();         expect_iir(8'hC4, "R10 receive data above timeout");
    rx_ready = 0; tick();         expect_iir(8'hCC, "R10 timeout back");
    rbr_rd = 1; tick();           expect_iir(8'hC1, "R10 cleared by buffer read");
    for (int i = 0; i < 4; i++) begin char_tick = 1; tick(); end
    expect_iir(8'hCC, "R10 timeout again");
    rx_char_evt = 1; tick();      expect_iir(8'hC1, "R10 cleared by new character");
    fifo_mode = 0;
    for (int i = 0; i < 5; i++) begin char_tick = 1; tick(); end
    expect_iir(8'h01, "R9 R10 no timeout outside fifo mode");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule